// File: doc/BRIEF.md
# Lowest-Priority Interrupt Destination Arbiter

This block decides which processor receives an interrupt that is delivered in lowest-priority mode. A request carries an 8-bit vector and a destination mask naming the processors that may take it. Each processor supplies its task priority byte and the priority class it is servicing now. The block derives an arbitration priority per processor and drops processors that mask the interrupt's class. Among the rest it grants the one with the lowest arbitration priority. A tie goes to the processor holding the highest arbitration ID.

The arbitration IDs are internal state. They start at the processor index and are rewritten after every grant, so that processors tied on priority take turns. The current IDs are visible on an output. A request is a one-cycle strobe. There is no back-pressure: the block accepts a request on every cycle, and each result is a one-cycle pulse that appears one clock after its strobe.

Top module: `lp_irq_arbiter`

## Requirements
- R1: During and right after reset, `grant_valid` and `grant_illegal` are 0 and `grant_onehot` is all zeros. The arbitration ID of processor i is i.
- R2: The interrupt's class is `req_vector[7:4]`. A vector of class 0 (0x00 to 0x0F) is illegal. It pulses `grant_illegal`, grants nothing and leaves every arbitration ID unchanged.
- R3: A processor's arbitration priority is the larger of its task priority class and its in-service class. The task priority class is bits [7:4] of its byte in `tpr_flat`, and bits [3:0] have no effect.
- R4: A processor is a candidate only if its `req_dest` bit is set and the interrupt's class is strictly greater than its task priority class. With no candidate, nothing is granted and the IDs are unchanged.
- R5: Of the candidates, the one with the lowest arbitration priority is granted.
- R6: Among candidates that share the lowest arbitration priority, the one with the highest arbitration ID is granted.
- R7: On a grant, the winner's ID becomes 0. Every processor whose ID was below the winner's old ID adds 1, and the other IDs keep their values. The IDs therefore remain a permutation of 0 to NPROC-1.
- R8: Results are registered. The `grant_valid`, `grant_onehot` and `grant_illegal` of a strobe appear in the cycle after the strobe and last one cycle. Without a strobe they are 0, and an empty destination mask grants nothing.
- R9: Strobes may come on consecutive cycles. Each strobe is judged against the IDs left by the grant of the strobe before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe |
| req_vector | input | 8 | Interrupt vector |
| req_dest | input | NPROC | Destination mask, bit i is processor i |
| tpr_flat | input | 8*NPROC | Task priority byte of processor i at bits [8i+7:8i] |
| isr_class_flat | input | 4*NPROC | In-service class of processor i at bits [4i+3:4i] |
| grant_valid | output | 1 | A processor was granted |
| grant_onehot | output | NPROC | One-hot grant |
| grant_illegal | output | 1 | The request carried a reserved vector |
| arb_id_flat | output | IDW*NPROC | Current arbitration ID of processor i at bits [IDW*i+IDW-1:IDW*i] |

## Verification
A grant and the ID rotation that follows from it take effect on the same clock edge. The next strobe is compared against the rotated IDs, so two strobes on consecutive cycles make the grant of the second depend on the update from the first. The bench sends tie requests back to back with all processors at equal priority. It checks that the winners go round in the order its own ID model predicts, and it compares the ID output after each grant.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int unsigned CLASS_W = 4;
  localparam int unsigned VEC_W   = 8;

  typedef logic [CLASS_W-1:0] class_t;

  function automatic class_t class_max(input class_t a, input class_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpa_prio_calc.sv
module lpa_prio_calc
  import lpa_pkg::*;
(
  input  logic   dest_bit,
  input  class_t irq_class,
  input  class_t task_class,
  input  class_t svc_class,
  output class_t arb_prio,
  output logic   eligible
);
  always_comb begin
    arb_prio = class_max(task_class, svc_class);
    eligible = dest_bit && (irq_class > task_class);
  end
endmodule

// File: rtl/lpa_select.sv
module lpa_select
  import lpa_pkg::*;
#(
  parameter int unsigned NPROC = 4,
  parameter int unsigned IDW   = 2
) (
  input  logic [NPROC-1:0] eligible,
  input  class_t           prio [NPROC],
  input  logic [IDW-1:0]   ids  [NPROC],
  output logic             any_win,
  output logic [NPROC-1:0] win_onehot,
  output logic [IDW-1:0]   win_id
);
  class_t best_prio;
  logic   found;

  always_comb begin
    found      = 1'b0;
    best_prio  = '1;
    win_id     = '0;
    win_onehot = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (eligible[i]) begin
        if (!found || (prio[i] < best_prio) ||
            ((prio[i] == best_prio) && (ids[i] > win_id))) begin
          found      = 1'b1;
          best_prio  = prio[i];
          win_id     = ids[i];
          win_onehot = '0;
          win_onehot[i] = 1'b1;
        end
      end
    end
    any_win = found;
  end
endmodule

// File: rtl/lpa_id_rotator.sv
module lpa_id_rotator #(
  parameter int unsigned NPROC = 4,
  parameter int unsigned IDW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [NPROC-1:0] win_onehot,
  input  logic [IDW-1:0]   win_id,
  output logic [IDW-1:0]   ids [NPROC]
);
  genvar gi, gj;
  generate
    for (gi = 0; gi < NPROC; gi++) begin : g_id
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ids[gi] <= IDW'(gi);
        end else if (fire) begin
          if (win_onehot[gi])
            ids[gi] <= '0;
          else if (ids[gi] < win_id)
            ids[gi] <= IDW'(ids[gi] + 1'b1);
        end
      end

      for (gj = gi + 1; gj < NPROC; gj++) begin : g_pair
        p_ids_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
          ids[gi] != ids[gj]);
      end

      p_winner_zeroed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && win_onehot[gi]) |=> (ids[gi] == '0));
      p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(ids[gi]));
    end
  endgenerate
endmodule

// File: rtl/lp_irq_arbiter.sv
module lp_irq_arbiter
  import lpa_pkg::*;
#(
  parameter int unsigned NPROC = 4,
  localparam int unsigned IDW  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [7:0]           req_vector,
  input  logic [NPROC-1:0]     req_dest,
  input  logic [8*NPROC-1:0]   tpr_flat,
  input  logic [4*NPROC-1:0]   isr_class_flat,
  output logic                 grant_valid,
  output logic [NPROC-1:0]     grant_onehot,
  output logic                 grant_illegal,
  output logic [IDW*NPROC-1:0] arb_id_flat
);
  class_t           irq_class;
  logic             illegal;
  class_t           prio [NPROC];
  logic [NPROC-1:0] eligible;
  logic [IDW-1:0]   ids  [NPROC];
  logic             any_win;
  logic [NPROC-1:0] win_onehot;
  logic [IDW-1:0]   win_id;
  logic             fire;
  logic [4*NPROC-1:0] unused_tpr_low;

  assign irq_class = req_vector[7:4];
  assign illegal   = (irq_class == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NPROC; gi++) begin : g_proc
      lpa_prio_calc u_calc (
        .dest_bit  (req_dest[gi]),
        .irq_class (irq_class),
        .task_class(tpr_flat[8*gi+4 +: 4]),
        .svc_class (isr_class_flat[4*gi +: 4]),
        .arb_prio  (prio[gi]),
        .eligible  (eligible[gi])
      );
      assign unused_tpr_low[4*gi +: 4] = tpr_flat[8*gi +: 4];
      assign arb_id_flat[IDW*gi +: IDW] = ids[gi];

      p_winner_id_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_onehot[gi]) |-> (ids[gi] == '0));
    end
  endgenerate

  lpa_select #(.NPROC(NPROC), .IDW(IDW)) u_sel (
    .eligible  (eligible),
    .prio      (prio),
    .ids       (ids),
    .any_win   (any_win),
    .win_onehot(win_onehot),
    .win_id    (win_id)
  );

  assign fire = req_valid && !illegal && any_win;

  lpa_id_rotator #(.NPROC(NPROC), .IDW(IDW)) u_rot (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .win_onehot(win_onehot),
    .win_id    (win_id),
    .ids       (ids)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid   <= 1'b0;
      grant_onehot  <= '0;
      grant_illegal <= 1'b0;
    end else begin
      grant_valid   <= fire;
      grant_onehot  <= fire ? win_onehot : '0;
      grant_illegal <= req_valid && illegal;
    end
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant_onehot) == 1));
  p_no_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_onehot == '0));
  p_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant_valid && !grant_illegal));
  p_illegal_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_illegal |-> !grant_valid);
  p_in_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !illegal) |=> ((grant_onehot & ~$past(req_dest)) == '0));
endmodule

// File: tb/lp_irq_arbiter_test.sv
module lp_irq_arbiter_test;
  localparam int NPROC = 4;
  localparam int IDW   = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic [7:0]           req_vector = '0;
  logic [NPROC-1:0]     req_dest = '0;
  logic [8*NPROC-1:0]   tpr_flat = '0;
  logic [4*NPROC-1:0]   isr_class_flat = '0;
  logic                 grant_valid;
  logic [NPROC-1:0]     grant_onehot;
  logic                 grant_illegal;
  logic [IDW*NPROC-1:0] arb_id_flat;

  int checks = 0;
  int errors = 0;
  int model_id [NPROC];

  always #2 clk = ~clk;

  lp_irq_arbiter #(.NPROC(NPROC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_dest(req_dest), .tpr_flat(tpr_flat), .isr_class_flat(isr_class_flat),
    .grant_valid(grant_valid), .grant_onehot(grant_onehot),
    .grant_illegal(grant_illegal), .arb_id_flat(arb_id_flat)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_ids(input string tag);
    for (int i = 0; i < NPROC; i++)
      check(int'(arb_id_flat[IDW*i +: IDW]) == model_id[i], tag,
            int'(arb_id_flat[IDW*i +: IDW]), model_id[i]);
  endtask

  // Expected winner from the requirements: eligibility (R4), priority (R3, R5), tie (R6).
  function automatic int exp_winner();
    int best = -1;
    int bp = 0;
    int v = int'(req_vector[7:4]);
    if (v == 0) return -1;
    for (int i = 0; i < NPROC; i++) begin
      int tc = int'(tpr_flat[8*i+4 +: 4]);
      int sc = int'(isr_class_flat[4*i +: 4]);
      int p = (tc > sc) ? tc : sc;
      if (req_dest[i] && v > tc) begin
        if (best < 0 || p < bp || (p == bp && model_id[i] > model_id[best])) begin
          best = i;
          bp = p;
        end
      end
    end
    return best;
  endfunction

  function automatic void model_rotate(input int w);
    int wid = model_id[w];
    for (int i = 0; i < NPROC; i++) begin
      if (i == w) model_id[i] = 0;
      else if (model_id[i] < wid) model_id[i]++;
    end
  endfunction

  task automatic set_proc(input int i, input logic [7:0] tpr, input logic [3:0] isr);
    tpr_flat[8*i +: 8] = tpr;
    isr_class_flat[4*i +: 4] = isr;
  endtask

  // Applies a strobe at a negedge; returns at the next negedge with results visible.
  task automatic strobe(input logic [7:0] vec, input logic [NPROC-1:0] dest,
                        input bit keep_valid, output int w);
    req_vector = vec;
    req_dest   = dest;
    req_valid  = 1'b1;
    w = exp_winner();
    @(negedge clk);
    req_valid = keep_valid;
    if (w >= 0) model_rotate(w);
  endtask

  task automatic check_result(input int w, input bit illegal, input string tag);
    int eo = (w >= 0) ? (1 << w) : 0;
    check(grant_valid == (w >= 0), {tag, " valid"}, int'(grant_valid), int'(w >= 0));
    check(int'(grant_onehot) == eo, {tag, " onehot"}, int'(grant_onehot), eo);
    check(grant_illegal == illegal, {tag, " illegal"}, int'(grant_illegal), int'(illegal));
    check_ids({tag, " ids"});
  endtask

  task automatic t_reset();
    for (int i = 0; i < NPROC; i++) model_id[i] = i;
    check(!grant_valid && !grant_illegal && grant_onehot == '0, "R1 outputs",
          int'({grant_valid, grant_illegal, grant_onehot}), 0);
    check_ids("R1 reset ids");
  endtask

  task automatic t_illegal();
    int w;
    for (int i = 0; i < NPROC; i++) set_proc(i, 8'h00, 4'h0);
    strobe(8'h0A, 4'b1111, 1'b0, w);
    check_result(-1, 1'b1, "R2 reserved vector");
    @(negedge clk);
    check(!grant_illegal, "R8 illegal pulse", int'(grant_illegal), 0);
  endtask

  task automatic t_lowest();
    int w;
    set_proc(0, 8'h00, 4'h5); set_proc(1, 8'h00, 4'h2);
    set_proc(2, 8'h00, 4'h7); set_proc(3, 8'h00, 4'h3);
    strobe(8'h80, 4'b1111, 1'b0, w);
    check(w == 1, "R5 model winner", w, 1);
    check_result(w, 1'b0, "R5 lowest priority");
    @(negedge clk);
    check(!grant_valid && grant_onehot == '0, "R8 grant pulse",
          int'({grant_valid, grant_onehot}), 0);
  endtask

  task automatic t_tie_rotation();
    int w;
    int order [4] = '{3, 2, 0, 1};
    for (int i = 0; i < NPROC; i++) set_proc(i, 8'h00, 4'h0);
    // R9: four back-to-back strobes, each seeing the IDs rotated by the one before.
    for (int k = 0; k < 4; k++) begin
      strobe(8'h50, 4'b1111, (k < 3), w);
      check_result(w, 1'b0, "R6 R7 R9 tie rotation");
      check(grant_onehot == NPROC'(1 << order[k]), "R6 rotation order",
            int'(grant_onehot), 1 << order[k]);
    end
    @(negedge clk);
  endtask

  task automatic t_max_and_low_nibble();
    int w;
    set_proc(0, 8'h3F, 4'h1); set_proc(1, 8'h10, 4'h4);
    strobe(8'h90, 4'b0011, 1'b0, w);
    check(w == 0, "R3 model winner", w, 0);
    check_result(w, 1'b0, "R3 low nibble ignored");
    set_proc(2, 8'h60, 4'h0); set_proc(3, 8'h00, 4'h5);
    strobe(8'h70, 4'b1100, 1'b0, w);
    check(w == 3, "R3 max model", w, 3);
    check_result(w, 1'b0, "R3 max of classes");
  endtask

  task automatic t_eligibility();
    int w;
    set_proc(0, 8'h40, 4'h0); set_proc(1, 8'h50, 4'h0);
    set_proc(2, 8'h20, 4'h9); set_proc(3, 8'h30, 4'h8);
    strobe(8'h40, 4'b1111, 1'b0, w);
    check(w == 3, "R4 model winner", w, 3);
    check_result(w, 1'b0, "R4 masked by task class");
    for (int i = 0; i < NPROC; i++) set_proc(i, 8'h20, 4'h0);
    strobe(8'h2F, 4'b1111, 1'b0, w);
    check_result(-1, 1'b0, "R4 no candidate");
  endtask

  task automatic t_empty_mask();
    int w;
    for (int i = 0; i < NPROC; i++) set_proc(i, 8'h00, 4'h0);
    strobe(8'h80, 4'b0000, 1'b0, w);
    check_result(-1, 1'b0, "R8 empty mask");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_lowest();
    t_tie_rotation();
    t_max_and_low_nibble();
    t_eligibility();
    t_empty_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule